// File: doc/BRIEF.md
# High-Speed USB Transmit Serializer

This block is the transmit half of a high-speed USB PHY as the link layer sees it. The link hands over packet bytes on an 8-bit bus with a valid/ready handshake. The block turns them into a serial line level. A bit-time enable, `bit_en`, paces all serial progress: one line bit is produced on each clock edge where it is high. Edges where it is low change nothing.

For each packet the block sends a synchronisation pattern, then the packet bytes least significant bit first, then an end-of-packet marker. A zero is stuffed after every run of six ones, and the whole stream is NRZI coded onto `line_out`. When the host-mode input is set and the first byte names a start-of-frame packet, the end marker is lengthened. During one fixed bit of that marker the block raises a strobe, so that a line comparator can sample for a device disconnect. Pacing between packets is the link's job: the block takes a new packet on the very next bit time after an end marker finishes.

Top module: `utmi_tx_serializer`

## Requirements
- R1: After reset, and on every `bit_en` edge in idle with `tx_valid` low, `line_out` is 1 (J), `line_active` is 0, `disc_sample` is 0 and `tx_ready` is 0.
- R2: `tx_ready` is high only in a cycle where `tx_valid` and `bit_en` are both high. A byte counts as taken at a rising edge where `tx_valid` and `tx_ready` are both high. While `tx_valid` stays high, one byte is taken per eight data bit times, plus one bit time for each stuffed zero.
- R3: A `bit_en` edge in idle with `tx_valid` high sends the first of 32 SYNC bits: 31 zeros, then a one. The first `tx_ready` pulse comes on the bit time of the last SYNC bit, and the byte taken then is the PID.
- R4: Each taken byte is sent least significant bit first, one bit per `bit_en` edge. Serial state does not advance on edges where `bit_en` is low.
- R5: After six consecutive logical ones, counting the final SYNC one, a zero is inserted without consuming a data bit. Stuffing resets the run. SYNC and the end marker's ones are never stuffed.
- R6: NRZI coding: a zero bit flips `line_out` and a one bit keeps it. The first SYNC bit always drives `line_out` from J (1) to K (0).
- R7: If `tx_valid` is low on the bit time where the next byte would be taken, the packet ends. `tx_ready` stays low until the SYNC of a later packet completes. A pending stuffed zero is sent before the end marker.
- R8: The end marker for a packet that is not start-of-frame is 8 bits: a zero followed by seven ones.
- R9: When `host_mode` is high at the moment the PID is taken and PID bits [3:0] equal 4'b0101, the end marker is 40 bits: a zero followed by 39 ones. `disc_sample` is high for exactly the 32nd bit of that marker (index 31, where the leading zero is index 0) and is low at all other times.
- R10: A `bit_en` edge right after the last end-marker bit, with `tx_valid` high, starts the next SYNC, and `line_active` stays high. With `tx_valid` low on that edge, the line returns to J and `line_active` falls.
- R11: `line_out`, `line_active` and `disc_sample` change only at rising edges where `bit_en` is high. They show the bit chosen at that edge until the next such edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Marks a clock edge that advances one serial bit |
| host_mode | input | 1 | Host operation; enables the long start-of-frame end marker |
| tx_data | input | 8 | Byte offered by the link |
| tx_valid | input | 1 | Link has a packet in progress and a byte on `tx_data` |
| tx_ready | output | 1 | Byte on `tx_data` is taken at this edge |
| line_out | output | 1 | NRZI line level, 1 = J, 0 = K |
| line_active | output | 1 | Transmitter is driving the line |
| disc_sample | output | 1 | Disconnect-sample window inside the start-of-frame end marker |

## Verification
The bench targets runs of ones that cross byte boundaries. A design that counts the run wrongly, or lets the stuff bit eat a data bit, shifts every later line level. A packet whose last byte leaves exactly six ones pending checks that the stuffed zero comes before the end marker and does not disappear into it. A start-of-frame PID is sent with host mode on and with host mode off, which catches a wrong marker length or a disconnect strobe at the wrong bit or in the wrong mode. Back-to-back packets and a sparse irregular `bit_en` check that no recovery gap is inserted and that no state moves between bit times.

// File: rtl/utx_pkg.sv
package utx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SYNC,
        ST_DATA,
        ST_EOP
    } tx_state_t;

    // Low nibble of the start-of-frame token
    localparam logic [3:0] SOF_PID_LOW = 4'b0101;

endpackage

// File: rtl/utx_stuff_ctl.sv
module utx_stuff_ctl #(
    parameter int STUFF_RUN = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    input  logic emit,
    input  logic bit_in,
    input  logic window,
    output logic stall
);
    localparam int RUN_W = $clog2(STUFF_RUN + 1);

    typedef struct packed {
        logic [RUN_W-1:0] run;
    } stuff_regs_t;

    stuff_regs_t r_q, r_d;

    assign stall = window && (r_q.run == RUN_W'(STUFF_RUN));

    always_comb begin
        r_d = r_q;
        if (strobe && emit) begin
            if (!bit_in) begin
                r_d.run = '0;
            end else if (r_q.run != RUN_W'(STUFF_RUN)) begin
                r_d.run = r_q.run + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    // R5: the serializer must put out a zero whenever a stuff is due
    a_r5_stuff_is_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && strobe && emit) |-> !bit_in);

    // R5: an inserted zero clears the run
    a_r5_run_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && strobe && emit) |=> (r_q.run == '0));

endmodule

// File: rtl/utx_nrzi.sv
module utx_nrzi (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    input  logic drive,
    input  logic restart,
    input  logic bit_in,
    output logic line,
    output logic active
);
    typedef struct packed {
        logic line;
        logic active;
    } nrzi_regs_t;

    nrzi_regs_t r_q, r_d;
    logic base;

    assign line   = r_q.line;
    assign active = r_q.active;

    always_comb begin
        r_d  = r_q;
        base = restart ? 1'b1 : r_q.line;
        if (strobe) begin
            if (drive) begin
                r_d.line   = bit_in ? base : ~base;
                r_d.active = 1'b1;
            end else begin
                r_d.line   = 1'b1;
                r_d.active = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{line: 1'b1, active: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    // R6: a one keeps the level, a zero flips it
    a_r6_one_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && drive && !restart && bit_in) |=> $stable(line));

    a_r6_zero_flips: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && drive && !restart && !bit_in) |=> (line != $past(line)));

    // R11: nothing moves without a bit strobe
    a_r11_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe |=> ($stable(line) && $stable(active)));

endmodule

// File: rtl/utmi_tx_serializer.sv
module utmi_tx_serializer
    import utx_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_LEN    = 32,
    parameter int STUFF_RUN   = 6,
    parameter int EOP_LEN     = 8,
    parameter int SOF_EOP_LEN = 40,
    parameter int DISC_BIT    = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              host_mode,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_ready,
    output logic              line_out,
    output logic              line_active,
    output logic              disc_sample
);
    localparam int MAX_LEN = (SYNC_LEN > SOF_EOP_LEN) ? SYNC_LEN : SOF_EOP_LEN;
    localparam int CNT_W   = $clog2(MAX_LEN + 1);
    localparam int BIT_W   = $clog2(DATA_W);

    localparam logic [CNT_W-1:0] SYNC_LAST = CNT_W'(SYNC_LEN - 1);
    localparam logic [CNT_W-1:0] EOP_LAST  = CNT_W'(EOP_LEN - 1);
    localparam logic [CNT_W-1:0] SOF_LAST  = CNT_W'(SOF_EOP_LEN - 1);
    localparam logic [CNT_W-1:0] DISC_IDX  = CNT_W'(DISC_BIT);
    localparam logic [BIT_W-1:0] BYTE_LAST = BIT_W'(DATA_W - 1);

    typedef struct packed {
        tx_state_t         st;
        logic [CNT_W-1:0]  cnt;
        logic [BIT_W-1:0]  bitn;
        logic [DATA_W-1:0] sh;
        logic              sof;
        logic              disc;
    } ser_regs_t;

    ser_regs_t r_q, r_d;

    logic emit, emit_bit, restart, load_pt, stuff_win, stall;
    logic [CNT_W-1:0] eop_last;

    utx_stuff_ctl #(
        .STUFF_RUN (STUFF_RUN)
    ) u_stuff (
        .clk    (clk),
        .rst_n  (rst_n),
        .strobe (bit_en),
        .emit   (emit),
        .bit_in (emit_bit),
        .window (stuff_win),
        .stall  (stall)
    );

    utx_nrzi u_nrzi (
        .clk     (clk),
        .rst_n   (rst_n),
        .strobe  (bit_en),
        .drive   (emit),
        .restart (restart),
        .bit_in  (emit_bit),
        .line    (line_out),
        .active  (line_active)
    );

    assign disc_sample = r_q.disc;

    always_comb begin
        r_d       = r_q;
        emit      = 1'b0;
        emit_bit  = 1'b0;
        restart   = 1'b0;
        eop_last  = r_q.sof ? SOF_LAST : EOP_LAST;
        stuff_win = (r_q.st == ST_DATA) || (r_q.st == ST_EOP && r_q.cnt == '0);
        load_pt   = (r_q.st == ST_SYNC && r_q.cnt == SYNC_LAST) ||
                    (r_q.st == ST_DATA && r_q.bitn == BYTE_LAST);
        tx_ready  = bit_en && tx_valid && load_pt && !stall;

        if (bit_en) begin
            r_d.disc = 1'b0;
            unique case (r_q.st)
                ST_IDLE: begin
                    if (tx_valid) begin
                        emit     = 1'b1;
                        restart  = 1'b1;
                        emit_bit = 1'b0;
                        r_d.st   = ST_SYNC;
                        r_d.cnt  = CNT_W'(1);
                        r_d.sof  = 1'b0;
                    end
                end
                ST_SYNC: begin
                    emit     = 1'b1;
                    emit_bit = (r_q.cnt == SYNC_LAST);
                    r_d.cnt  = r_q.cnt + 1'b1;
                end
                ST_DATA: begin
                    emit = 1'b1;
                    if (stall) begin
                        emit_bit = 1'b0;
                    end else begin
                        emit_bit = r_q.sh[0];
                        r_d.sh   = r_q.sh >> 1;
                        r_d.bitn = r_q.bitn + 1'b1;
                    end
                end
                ST_EOP: begin
                    emit = 1'b1;
                    if (stall) begin
                        emit_bit = 1'b0;
                    end else begin
                        emit_bit = (r_q.cnt != '0);
                        r_d.disc = r_q.sof && (r_q.cnt == DISC_IDX);
                        r_d.cnt  = r_q.cnt + 1'b1;
                        if (r_q.cnt == eop_last) begin
                            r_d.st = ST_IDLE;
                        end
                    end
                end
                default: r_d.st = ST_IDLE;
            endcase

            if (load_pt && !stall) begin
                if (tx_valid) begin
                    r_d.sh   = tx_data;
                    r_d.bitn = '0;
                    r_d.st   = ST_DATA;
                    if (r_q.st == ST_SYNC) begin
                        r_d.sof = host_mode && (tx_data[3:0] == SOF_PID_LOW);
                    end
                end else begin
                    r_d.st  = ST_EOP;
                    r_d.cnt = '0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, cnt: '0, bitn: '0, sh: '0, sof: 1'b0, disc: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    // R2: a byte is only offered to be taken on a bit time with valid data
    a_r2_ready_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> (tx_valid && bit_en));

    // R7: no handshake while the end marker is going out
    a_r7_quiet_in_eop: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_EOP) |-> !tx_ready);

    // R9: the disconnect strobe only inside a driven start-of-frame marker
    a_r9_disc_in_sof: assert property (@(posedge clk) disable iff (!rst_n)
        disc_sample |-> (r_q.sof && line_active));

    // R1: an undriven line rests at J
    a_r1_idle_is_j: assert property (@(posedge clk) disable iff (!rst_n)
        !line_active |-> line_out);

endmodule

// File: tb/utmi_tx_serializer_test.sv
module utmi_tx_serializer_test;
    localparam int CLK_PERIOD = 10;
    localparam int MAX_CYCLES = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_en = 1'b0;
    logic       host_mode = 1'b0;
    logic       tx_valid = 1'b0;
    logic [7:0] tx_data = 8'h00;
    wire        tx_ready, line_out, line_active, disc_sample;

    always #(CLK_PERIOD / 2) clk = ~clk;

    utmi_tx_serializer uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .bit_en      (bit_en),
        .host_mode   (host_mode),
        .tx_data     (tx_data),
        .tx_valid    (tx_valid),
        .tx_ready    (tx_ready),
        .line_out    (line_out),
        .line_active (line_active),
        .disc_sample (disc_sample)
    );

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    // reference model state
    int  q[$];           // bit0 = value, bit1 = may be stuffed, bit2 = disconnect strobe
    bit  m_in_pkt = 0, m_ending = 0, m_first = 0, m_sof = 0, m_lvl = 1;
    int  m_run = 0;
    bit  e_line = 1, e_act = 0, e_disc = 0;

    // link model
    byte pkt[$];
    int  idx = 0;
    int  consumed = 0;
    int  disc_rises = 0;
    int  act_drops = 0;
    bit  prev_disc = 0;
    int  lfsr = 32'h1ace;
    string tag = "R1 idle";

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b (cycle %0d)", req, act, exp, cycles);
        end
    endtask

    task automatic check_int(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic model_step(input bit be, output bit rdy);
        bit stl, b, d;
        int e, n;
        stl = m_in_pkt && q.size() > 0 && m_run >= 6 && q[0][1];
        rdy = be && m_in_pkt && !m_ending && tx_valid && q.size() == 1 && !stl;
        if (!be) return;
        if (!m_in_pkt && tx_valid) begin
            m_in_pkt = 1; m_ending = 0; m_first = 1; m_sof = 0; m_lvl = 1; m_run = 0;
            for (int i = 0; i < 31; i++) q.push_back(0);
            q.push_back(1);
        end
        if (m_in_pkt) begin
            stl = m_run >= 6 && q[0][1];
            if (stl) begin
                b = 0; d = 0;
            end else begin
                e = q.pop_front(); b = e[0]; d = e[2];
            end
            if (!b) m_lvl = ~m_lvl;
            m_run = b ? m_run + 1 : 0;
            e_line = m_lvl; e_act = 1; e_disc = d;
            if (!stl && !m_ending && q.size() == 0) begin
                if (tx_valid) begin
                    for (int i = 0; i < 8; i++) q.push_back(2 | int'(tx_data[i]));
                    if (m_first) m_sof = host_mode && (tx_data[3:0] == 4'b0101);
                    m_first = 0;
                end else begin
                    m_ending = 1;
                    n = m_sof ? 40 : 8;
                    q.push_back(2);
                    for (int k = 1; k < n; k++) q.push_back(1 | ((m_sof && k == 31) ? 4 : 0));
                end
            end else if (m_ending && !stl && q.size() == 0) begin
                m_in_pkt = 0;
            end
        end else begin
            e_line = 1; e_act = 0; e_disc = 0;
        end
    endtask

    task automatic cycle(input bit sparse);
        bit rdy;
        @(negedge clk);
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        bit_en = sparse ? (lfsr[2:1] != 2'b00 && lfsr[4]) : 1'b1;
        #1;
        cycles++;
        check({tag, " / R6 line_out"}, line_out, e_line);
        check({tag, " / R10 line_active"}, line_active, e_act);
        check({tag, " / R9 disc_sample"}, disc_sample, e_disc);
        if (!line_active) act_drops++;
        if (disc_sample && !prev_disc) disc_rises++;
        prev_disc = disc_sample;
        model_step(bit_en, rdy);
        check({tag, " / R2 tx_ready"}, tx_ready, rdy);
        @(posedge clk);
        #1;
        if (tx_valid && rdy) begin
            consumed++;
            idx++;
            if (idx < pkt.size()) tx_data = pkt[idx];
            else begin
                tx_valid = 1'b0;
                tx_data  = 8'h00;
            end
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cycle(1'b0);
    endtask

    task automatic send(input byte b[$], input bit host, input bit sparse, input string t);
        pkt = b; idx = 0; consumed = 0; disc_rises = 0;
        tag = t;
        host_mode = host;
        tx_valid = 1'b1;
        tx_data = pkt[0];
        do cycle(sparse); while ((tx_valid || m_in_pkt) && cycles < MAX_CYCLES);
        check_int({t, " / R2 bytes taken"}, consumed, b.size());
    endtask

    initial begin
        #(CLK_PERIOD * (MAX_CYCLES + 1000));
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        byte p[$];
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        check("R1 reset line_out", line_out, 1'b1);
        check("R1 reset line_active", line_active, 1'b0);
        check("R1 reset disc_sample", disc_sample, 1'b0);
        check("R1 reset tx_ready", tx_ready, 1'b0);
        idle(6);

        // R3, R4: plain packet, LSB first after SYNC
        p = '{8'hC3, 8'h00, 8'h12, 8'h34};
        send(p, 1'b0, 1'b0, "R3 R4 plain");
        idle(5);

        // R5, R7: runs of ones, last byte leaves a stuff due before the end marker
        p = '{8'h4B, 8'hFF, 8'hFF, 8'hFF};
        send(p, 1'b0, 1'b0, "R5 R7 stuffing");
        idle(4);

        // R9: start-of-frame in host mode, long marker with one strobe
        p = '{8'hA5, 8'h3C, 8'hF8};
        send(p, 1'b1, 1'b0, "R9 sof host");
        check_int("R9 disconnect strobes in sof", disc_rises, 1);
        idle(4);

        // R8, R9: same token without host mode gives the short marker
        send(p, 1'b0, 1'b0, "R8 sof token device");
        check_int("R9 no strobe without host mode", disc_rises, 0);
        idle(4);

        // R9: host mode with a non-sof token
        p = '{8'h69, 8'h81};
        send(p, 1'b1, 1'b0, "R8 host data");
        check_int("R9 no strobe for other token", disc_rises, 0);
        idle(3);

        // R10: back-to-back packets, no idle bit in between
        p = '{8'h2D, 8'hFE, 8'h7F};
        send(p, 1'b0, 1'b0, "R10 first");
        act_drops = 0;
        p = '{8'hD2, 8'hFF};
        send(p, 1'b0, 1'b0, "R10 second");
        check_int("R10 line stays driven between packets", act_drops, 0);
        idle(4);

        // R11, R4: irregular bit strobes
        p = '{8'hA5, 8'hFF, 8'h01, 8'hFC};
        send(p, 1'b1, 1'b1, "R11 sparse sof");
        check_int("R11 R9 one strobe under sparse timing", disc_rises, 1);
        p = '{8'hE1, 8'h7E, 8'hFF, 8'h3F};
        send(p, 1'b0, 1'b1, "R11 R5 sparse stuffing");
        idle(10);

        // R7: packet that ends right after its PID
        p = '{8'h4B};
        send(p, 1'b0, 1'b0, "R7 pid only");
        idle(5);

        if (cycles >= MAX_CYCLES) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected fewer than %0d", cycles, MAX_CYCLES);
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule